// File: doc/BRIEF.md
# Byte-Order Reversal Coprocessor

This unit sits beside a CPU as an external coprocessor. The CPU raises a one-cycle start strobe together with a 24-bit opcode and a 128-bit operand bus. The operand bus holds steady while the operation runs. The unit decodes the opcode, picks one 32-bit or 64-bit operand from the lane layout for that size, and reverses its byte order. It then returns the result in the lane the CPU reads for that size, and marks completion with a one-cycle done pulse.

The result is held in a register, so done rises on the cycle after an accepted start. An opcode the unit does not recognise still completes with done and returns zero, so the CPU can never stall waiting for it. A start strobe that arrives while the unit is still completing an operation is dropped.

Opcode encoding: bits 7:0 hold the function code, which must equal `FUNC_CODE` (default 8'hA5). Bit 8 selects the size: 0 means 32-bit and 1 means 64-bit. Bit 9 selects the second operand slot. Bits 23:10 must be zero.

Top module: `bswap_cop`

## Requirements
- R1: While reset is active and on the first cycle after it, `done` is 0 and `result` is all zeros.
- R2: A start is accepted when `go` is 1 and `done` is 0 at a rising edge. `done` is then 1 on the following cycle only, for exactly one cycle.
- R3: A `go` sampled while `done` is 1 is ignored. No `done` follows it, and `result` keeps its value.
- R4: For a 32-bit opcode (bit 8 = 0, bit 9 = 0), `result[63:32]` is `operand[31:0]` with its four bytes reversed, and `result[31:0]` is zero.
- R5: For a 64-bit opcode (bit 8 = 1, bit 9 = 0), `result[63:0]` is `operand[63:0]` with its eight bytes reversed.
- R6: For a 32-bit opcode with bit 9 = 1, the swapped word is taken from `operand[95:64]` and placed on `result[63:32]`, and `result[31:0]` is zero.
- R7: For a 64-bit opcode with bit 9 = 1, the swapped value is taken from `operand[127:64]`.
- R8: An opcode whose bits 7:0 differ from `FUNC_CODE`, or whose bits 23:10 are not all zero, still produces the `done` pulse, and `result` becomes zero.
- R9: `result` changes only on the cycle after an accepted start. Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Start strobe, active high |
| opcode | input | 24 | Three opcode bytes |
| operand | input | 128 | Operand bus, held static during the operation |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Result bus |

## Verification
Both `done` and `result` come from one register stage. A start accepted at edge k therefore shows its result and done pulse after edge k+1's predecessor, that is, from edge k until edge k+1. The bench drives inputs on the falling edge and samples one falling edge after the start. It samples one falling edge later again to confirm that `done` has dropped and `result` has held. For dropped strobes, the bench fires `go` in the done cycle and checks on the next falling edge that no pulse appeared and the earlier result is unchanged.

// File: rtl/bswap_pkg.sv
package bswap_pkg;
  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 32;
  localparam int DWORD_W  = 64;
  localparam int OP_W     = 24;
  localparam int IN_W     = 2 * DWORD_W;
  localparam int RES_W    = DWORD_W;
  localparam int FUNC_W   = 8;
  localparam int SIZE_BIT = 8;
  localparam int SEL_BIT  = 9;
  localparam int RSV_LO   = 10;

  // Reverse the byte order of a 32-bit word.
  function automatic logic [WORD_W-1:0] swap_word(input logic [WORD_W-1:0] x);
    logic [WORD_W-1:0] y;
    for (int i = 0; i < WORD_W/BYTE_W; i++)
      y[i*BYTE_W +: BYTE_W] = x[(WORD_W/BYTE_W-1-i)*BYTE_W +: BYTE_W];
    return y;
  endfunction

  // Reverse the byte order of a 64-bit double word.
  function automatic logic [DWORD_W-1:0] swap_dword(input logic [DWORD_W-1:0] x);
    logic [DWORD_W-1:0] y;
    for (int i = 0; i < DWORD_W/BYTE_W; i++)
      y[i*BYTE_W +: BYTE_W] = x[(DWORD_W/BYTE_W-1-i)*BYTE_W +: BYTE_W];
    return y;
  endfunction
endpackage

// File: rtl/bswap_decode.sv
module bswap_decode
  import bswap_pkg::*;
#(
  parameter logic [FUNC_W-1:0] FUNC_CODE = 8'hA5
) (
  input  logic [OP_W-1:0] opcode,
  output logic            op_valid,
  output logic            op_size64,
  output logic            op_sel_hi
);
  logic func_hit;
  logic rsv_clear;

  always_comb begin
    func_hit  = (opcode[FUNC_W-1:0] == FUNC_CODE);
    rsv_clear = (opcode[OP_W-1:RSV_LO] == '0);
    op_valid  = func_hit && rsv_clear;
    op_size64 = opcode[SIZE_BIT];
    op_sel_hi = opcode[SEL_BIT];
  end
endmodule

// File: rtl/bswap_datapath.sv
module bswap_datapath
  import bswap_pkg::*;
(
  input  logic [IN_W-1:0]  operand,
  input  logic             op_valid,
  input  logic             op_size64,
  input  logic             op_sel_hi,
  output logic [RES_W-1:0] res_next
);
  localparam int HI_BASE = DWORD_W;
  localparam int PAD_W   = RES_W - WORD_W;

  logic [WORD_W-1:0]  word_in;
  logic [DWORD_W-1:0] dword_in;

  always_comb begin
    word_in  = op_sel_hi ? operand[HI_BASE +: WORD_W]  : operand[0 +: WORD_W];
    dword_in = op_sel_hi ? operand[HI_BASE +: DWORD_W] : operand[0 +: DWORD_W];
    if (!op_valid)
      res_next = '0;
    else if (op_size64)
      res_next = swap_dword(dword_in);
    else
      res_next = {swap_word(word_in), {PAD_W{1'b0}}};
  end
endmodule

// File: rtl/bswap_cop.sv
module bswap_cop
  import bswap_pkg::*;
#(
  parameter logic [7:0] FUNC_CODE = 8'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [23:0]   opcode,
  input  logic [127:0]  operand,
  output logic          done,
  output logic [63:0]   result
);
  logic             op_valid;
  logic             op_size64;
  logic             op_sel_hi;
  logic [RES_W-1:0] res_next;
  logic             accept;
  logic             done_q;
  logic [RES_W-1:0] result_q;

  bswap_decode #(.FUNC_CODE(FUNC_CODE)) u_dec (
    .opcode    (opcode),
    .op_valid  (op_valid),
    .op_size64 (op_size64),
    .op_sel_hi (op_sel_hi)
  );

  bswap_datapath u_dp (
    .operand   (operand),
    .op_valid  (op_valid),
    .op_size64 (op_size64),
    .op_sel_hi (op_sel_hi),
    .res_next  (res_next)
  );

  assign accept = go && !done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= accept;
      if (accept) result_q <= res_next;
    end
  end

  assign done   = done_q;
  assign result = result_q;
endmodule

// File: rtl/bswap_cop_chk.sv
module bswap_cop_chk #(
  parameter logic [7:0] FUNC_CODE = 8'hA5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          go,
  input logic [23:0]   opcode,
  input logic          done,
  input logic [63:0]   result,
  input logic          accept,
  input logic          op_valid,
  input logic          op_size64
);
  AST_DONE_FOLLOWS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !done) |=> done); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(go && !done) |=> !done); // R3
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(go && !done) |=> $stable(result)); // R9
  AST_BAD_OP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !done && ((opcode[7:0] != FUNC_CODE) || (opcode[23:10] != '0))) |=> (result == '0)); // R8
  AST_WORD_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_valid && !op_size64) |=> (result[31:0] == '0)); // R4
endmodule

bind bswap_cop bswap_cop_chk #(.FUNC_CODE(FUNC_CODE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .go        (go),
  .opcode    (opcode),
  .done      (done),
  .result    (result),
  .accept    (accept),
  .op_valid  (op_valid),
  .op_size64 (op_size64)
);

// File: tb/tb_bswap_cop.sv
module tb_bswap_cop;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          go = 1'b0;
  logic [23:0]   opcode = '0;
  logic [127:0]  operand = '0;
  logic          done;
  logic [63:0]   result;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] lfsr = 64'h0123_4567_89AB_CDEF;

  bswap_cop dut (
    .clk(clk), .rst_n(rst_n), .go(go), .opcode(opcode),
    .operand(operand), .done(done), .result(result)
  );

  always #4 clk = ~clk;

  function automatic logic [63:0] rev_bytes(input logic [63:0] x, input int nbytes);
    logic [63:0] e = '0;
    for (int i = 0; i < nbytes; i++)
      e = (e << 8) | ((x >> (8*i)) & 64'hFF);
    return e;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
  endtask

  // Issue one start at a falling edge; check done and result one falling edge later,
  // then check done dropped and result held on the following falling edge.
  task automatic run_op(input string req, input logic [23:0] op, input logic [127:0] opd,
                        input logic [63:0] exp);
    @(negedge clk);
    go = 1'b1; opcode = op; operand = opd;
    @(negedge clk);
    go = 1'b0;
    check({req, " done"}, {63'b0, done}, 64'd1);
    check(req, result, exp);
    @(negedge clk);
    check("R2 done width", {63'b0, done}, 64'd0);
    check("R9 hold", result, exp);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [127:0] opd;
    logic [63:0]  exp;
    logic [63:0]  held;
    // R1: reset state
    #3;
    check("R1 done in reset", {63'b0, done}, 64'd0);
    check("R1 result in reset", result, 64'd0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after reset", {63'b0, done}, 64'd0);
    check("R1 result after reset", result, 64'd0);

    // Sweep sizes and operand slots over many operand patterns
    for (int k = 0; k < 64; k++) begin
      step_lfsr(); opd[63:0] = lfsr;
      step_lfsr(); opd[127:64] = lfsr;
      if (k == 0) opd = {64'hFEDC_BA98_7654_3210, 64'h0011_2233_4455_6677};
      exp = rev_bytes({32'h0, opd[31:0]}, 4) << 32;
      run_op("R4 word lo", 24'h0000A5, opd, exp);
      run_op("R5 dword lo", 24'h0001A5, opd, rev_bytes(opd[63:0], 8));
      exp = rev_bytes({32'h0, opd[95:64]}, 4) << 32;
      run_op("R6 word hi", 24'h0002A5, opd, exp);
      run_op("R7 dword hi", 24'h0003A5, opd, rev_bytes(opd[127:64], 8));
    end
    check("R4 fixed", rev_bytes(64'h0000_0000_0A0B_0C0D, 4), 64'h0D0C_0B0A);

    // R8: unrecognised codes
    opd = {64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888};
    run_op("R5 prime", 24'h0001A5, opd, rev_bytes(opd[63:0], 8));
    run_op("R8 bad func", 24'h0001A4, opd, 64'd0);
    run_op("R8 bad func 00", 24'h000000, opd, 64'd0);
    run_op("R8 reserved set", 24'h0401A5, opd, 64'd0);
    run_op("R8 top reserved", 24'h8000A5, opd, 64'd0);

    // R3: go during done is ignored
    run_op("R5 base", 24'h0001A5, opd, rev_bytes(opd[63:0], 8));
    held = rev_bytes(opd[63:0], 8);
    @(negedge clk);
    go = 1'b1; opcode = 24'h0001A5;
    @(negedge clk);
    check("R2 first done", {63'b0, done}, 64'd1);
    check("R9 first result", result, held);
    opcode = 24'h0003A5; operand = ~opd;   // go still high during done cycle
    @(negedge clk);
    go = 1'b0;
    check("R3 no done", {63'b0, done}, 64'd0);
    check("R3 result kept", result, held);
    @(negedge clk);
    check("R9 idle hold", result, held);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule